// File: doc/BRIEF.md
# Transfer Address Sequencer with Circular and Ping-Pong Buffers

This block generates the source and destination byte addresses for each beat of a single memory-to-memory transfer. A load strobe captures a set of transfer settings: two base addresses per side, a beat count, a beat size code, per-side circular-buffer controls and a ping-pong enable. After each completed beat the block is told to advance. Both pointers then step by the beat size, and the remaining count drops by one. When the last beat completes, a one-cycle completion pulse is raised.

Each side can confine its pointer to an aligned window of 2^k bytes. Only the low k address bits then count, and the upper bits hold. In ping-pong mode a swap request is held until the next beat boundary. At that boundary both pointers jump to the start of the other buffer, instead of stepping. A chained reload replaces the settings in flight and restarts the transfer only when its auto-run bit is set.

All outputs are registered. The bus transactions themselves belong to the surrounding engine.

Top module: `dma_addr_gen`

## Requirements
- R1: After a synchronous reset, both addresses, the remaining count, `active`, `done` and `buf_sel` are all zero.
- R2: One cycle after `start`, the addresses equal the primary (buffer 0) bases and `remaining` equals `cfg_count`. `buf_sel` is 0, and `active` is 1 exactly when `cfg_count` is nonzero.
- R3: The beat size code `cfg_width` means 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 4 bytes. Each accepted advance adds that many bytes to each pointer.
- R4: When a side's circular mode is on with window exponent k from 1 to 15, an advance changes only the low k bits of that pointer, modulo 2^k, and bits 31..k hold. With the mode off or with k = 0, the pointer is a plain 32-bit counter.
- R5: Each accepted advance lowers `remaining` by one. The advance that takes it from 1 to 0 makes `active` 0 and `done` 1 on the next cycle. `done` is 1 for exactly that one cycle.
- R6: With ping-pong enabled, a `buf_swap` request while active leaves the addresses unchanged until the next accepted advance, which may be in the same cycle. At that advance `buf_sel` toggles and both pointers load the bases of the newly selected buffer (0 = primary, 1 = alternate) instead of stepping.
- R7: With ping-pong disabled in the captured settings, `buf_swap` has no effect: `buf_sel` stays 0 and advances keep stepping.
- R8: `advance` while `active` is 0 changes no output.
- R9: `ll_load` captures new settings exactly like `start`, clears any held swap request and sets `buf_sel` to 0. `active` becomes 1 only when `cfg_auto` is 1 and the count is nonzero.
- R10: When `start` or `ll_load` arrives in the same cycle as `advance`, the load wins and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture settings and run |
| ll_load | input | 1 | Chained reload of settings |
| advance | input | 1 | One beat has completed |
| buf_swap | input | 1 | Request a switch to the other buffer |
| cfg_src_a | input | 32 | Source base, buffer 0 |
| cfg_src_b | input | 32 | Source base, buffer 1 |
| cfg_dst_a | input | 32 | Destination base, buffer 0 |
| cfg_dst_b | input | 32 | Destination base, buffer 1 |
| cfg_count | input | 16 | Number of beats |
| cfg_width | input | 2 | Beat size code |
| cfg_src_wrap | input | 1 | Source circular mode on |
| cfg_src_wrap_k | input | 4 | Source window exponent |
| cfg_dst_wrap | input | 1 | Destination circular mode on |
| cfg_dst_wrap_k | input | 4 | Destination window exponent |
| cfg_dbuf | input | 1 | Ping-pong mode on |
| cfg_auto | input | 1 | Chained reload starts the transfer |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| remaining | output | 16 | Beats left |
| active | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| buf_sel | output | 1 | Buffer in use |

## Verification
Every result is due exactly one clock edge after the strobe that causes it. This covers loads, steps, wraps, swaps and the completion pulse, because each passes through a single register stage. The only exception is a swap request without an advance: it changes no output until the next accepted advance. The bench drives the strobes, waits for one rising edge, and compares every output a short delay after that edge against a model advanced by the same single step. The check for a held swap therefore confirms that the addresses stay unchanged in the cycle of the request, and that the jump appears in the cycle after the following advance.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    BEAT_B1 = 2'd0,
    BEAT_B2 = 2'd1,
    BEAT_B4 = 2'd2,
    BEAT_B4X = 2'd3
  } beat_e;

  function automatic logic [STEP_W-1:0] beat_bytes(input logic [1:0] code);
    case (beat_e'(code))
      BEAT_B1: beat_bytes = 3'd1;
      BEAT_B2: beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_ag_ptr.sv
module dma_ag_ptr
  import dma_ag_pkg::*;
#(
  parameter int AW = 32,
  parameter int KW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW-1:0]     ld_base_a,
  input  logic [AW-1:0]     ld_base_b,
  input  logic              ld_wrap_en,
  input  logic [KW-1:0]     ld_wrap_k,
  input  logic [STEP_W-1:0] ld_step,
  input  logic              move,
  input  logic              swap_now,
  input  logic              sel_next,
  output logic [AW-1:0]     addr
);
  logic [AW-1:0]     base_a, base_b, addr_q, mask, inc, stepped;
  logic              wrap_en;
  logic [KW-1:0]     wrap_k;
  logic [STEP_W-1:0] step;

  always_comb begin
    if (wrap_en && (wrap_k != '0)) mask = (AW'(1) << wrap_k) - AW'(1);
    else                           mask = '1;
    inc     = addr_q + AW'(step);
    stepped = (addr_q & ~mask) | (inc & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a  <= '0;
      base_b  <= '0;
      wrap_en <= 1'b0;
      wrap_k  <= '0;
      step    <= '0;
      addr_q  <= '0;
    end else if (load) begin
      base_a  <= ld_base_a;
      base_b  <= ld_base_b;
      wrap_en <= ld_wrap_en;
      wrap_k  <= ld_wrap_k;
      step    <= ld_step;
      addr_q  <= ld_base_a;
    end else if (move) begin
      if (swap_now) addr_q <= sel_next ? base_b : base_a;
      else          addr_q <= stepped;
    end
  end

  assign addr = addr_q;

  // R3: without a window, an advance adds exactly the beat size
  a_r3_plain_step: assert property (@(posedge clk) disable iff (rst)
    (move && !swap_now && !(wrap_en && wrap_k != '0)) |=> addr == $past(addr) + AW'($past(step)));

  // R4: bits above the window never change on a step
  a_r4_upper_hold: assert property (@(posedge clk) disable iff (rst)
    (move && !swap_now) |=> ((addr ^ $past(addr)) & ~$past(mask)) == '0);

  // R6: a swap lands on the base of the chosen buffer
  a_r6_swap_base: assert property (@(posedge clk) disable iff (rst)
    (move && swap_now) |=> addr == ($past(sel_next) ? base_b : base_a));
endmodule

// File: rtl/dma_ag_ctl.sv
module dma_ag_ctl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_go,
  input  logic [CW-1:0] ld_count,
  input  logic          ld_dbuf,
  input  logic          advance,
  input  logic          swap_req,
  output logic          move,
  output logic          swap_now,
  output logic          sel_next,
  output logic [CW-1:0] remaining,
  output logic          active,
  output logic          done,
  output logic          buf_sel
);
  logic [CW-1:0] rem_q;
  logic          act_q, done_q, sel_q, pend_q, dbuf_q;

  always_comb begin
    move     = act_q && advance && !load;
    swap_now = move && dbuf_q && (pend_q || swap_req);
    sel_next = ~sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
      dbuf_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        rem_q  <= ld_count;
        act_q  <= load_go && (ld_count != '0);
        sel_q  <= 1'b0;
        pend_q <= 1'b0;
        dbuf_q <= ld_dbuf;
      end else if (move) begin
        rem_q  <= rem_q - CW'(1);
        pend_q <= 1'b0;
        if (swap_now) sel_q <= sel_next;
        if (rem_q == CW'(1)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (act_q && dbuf_q && swap_req) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign remaining = rem_q;
  assign active    = act_q;
  assign done      = done_q;
  assign buf_sel   = sel_q;

  // R5: one beat consumed per accepted advance
  a_r5_count_dec: assert property (@(posedge clk) disable iff (rst)
    (active && advance && !load) |=> remaining == $past(remaining) - CW'(1));

  // R5: completion is a single-cycle pulse with the transfer idle
  a_r5_done_once: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && remaining == '0));

  // R8: an idle sequencer holds its count
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!active && !load) |=> $stable(remaining));

  // R6: the buffer selection only moves on a beat boundary or a load
  a_r6_sel_boundary: assert property (@(posedge clk) disable iff (rst)
    (!move && !load) |=> $stable(buf_sel));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ll_load,
  input  logic          advance,
  input  logic          buf_swap,
  input  logic [AW-1:0] cfg_src_a,
  input  logic [AW-1:0] cfg_src_b,
  input  logic [AW-1:0] cfg_dst_a,
  input  logic [AW-1:0] cfg_dst_b,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_src_wrap,
  input  logic [KW-1:0] cfg_src_wrap_k,
  input  logic          cfg_dst_wrap,
  input  logic [KW-1:0] cfg_dst_wrap_k,
  input  logic          cfg_dbuf,
  input  logic          cfg_auto,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] remaining,
  output logic          active,
  output logic          done,
  output logic          buf_sel
);
  localparam int SIDES = 2;

  logic load, load_go, move, swap_now, sel_next;
  logic [STEP_W-1:0] step;
  logic [SIDES-1:0][AW-1:0] base_a, base_b, addr;
  logic [SIDES-1:0]         wrap_en;
  logic [SIDES-1:0][KW-1:0] wrap_k;

  always_comb begin
    load    = start | ll_load;
    load_go = start | (ll_load & cfg_auto);
    step    = beat_bytes(cfg_width);
    base_a  = {cfg_dst_a, cfg_src_a};
    base_b  = {cfg_dst_b, cfg_src_b};
    wrap_en = {cfg_dst_wrap, cfg_src_wrap};
    wrap_k  = {cfg_dst_wrap_k, cfg_src_wrap_k};
  end

  dma_ag_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .load(load), .load_go(load_go),
    .ld_count(cfg_count), .ld_dbuf(cfg_dbuf), .advance(advance),
    .swap_req(buf_swap), .move(move), .swap_now(swap_now),
    .sel_next(sel_next), .remaining(remaining), .active(active),
    .done(done), .buf_sel(buf_sel)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dma_ag_ptr #(.AW(AW), .KW(KW)) u_ptr (
      .clk(clk), .rst(rst), .load(load),
      .ld_base_a(base_a[g]), .ld_base_b(base_b[g]),
      .ld_wrap_en(wrap_en[g]), .ld_wrap_k(wrap_k[g]), .ld_step(step),
      .move(move), .swap_now(swap_now), .sel_next(sel_next),
      .addr(addr[g])
    );
  end

  assign src_addr = addr[0];
  assign dst_addr = addr[1];

  // R10: a load in the same cycle as an advance yields the loaded count
  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> (remaining == $past(cfg_count) && src_addr == $past(cfg_src_a)));
endmodule

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, ll_load = 0, advance = 0, buf_swap = 0;
  logic [31:0] cfg_src_a = 0, cfg_src_b = 0, cfg_dst_a = 0, cfg_dst_b = 0;
  logic [15:0] cfg_count = 0;
  logic [1:0]  cfg_width = 0;
  logic        cfg_src_wrap = 0, cfg_dst_wrap = 0, cfg_dbuf = 0, cfg_auto = 0;
  logic [3:0]  cfg_src_wrap_k = 0, cfg_dst_wrap_k = 0;
  logic [31:0] src_addr, dst_addr;
  logic [15:0] remaining;
  logic        active, done, buf_sel;

  int total = 0, bad = 0;

  // model state
  logic [31:0] m_src, m_dst, m_sa, m_sb, m_da, m_db;
  logic [15:0] m_rem;
  logic m_act, m_done, m_sel, m_pend, m_dbuf, m_se, m_de;
  logic [3:0] m_sk, m_dk;
  logic [2:0] m_step;

  always #10 clk = ~clk;

  dma_addr_gen uut (.*);

  initial begin
    #4000000;
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] nxt(input logic [31:0] a, input logic [2:0] st,
                                      input logic en, input logic [3:0] k);
    logic [31:0] msk;
    msk = (en && k != 0) ? ((32'd1 << k) - 32'd1) : 32'hFFFF_FFFF;
    return (a & ~msk) | ((a + 32'(st)) & msk);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "src_addr", src_addr, m_src);
    chk(tag, "dst_addr", dst_addr, m_dst);
    chk(tag, "remaining", 32'(remaining), 32'(m_rem));
    chk(tag, "active", 32'(active), 32'(m_act));
    chk(tag, "done", 32'(done), 32'(m_done));
    chk(tag, "buf_sel", 32'(buf_sel), 32'(m_sel));
  endtask

  // one clock with the given strobes; model advanced by the same step
  task automatic cyc(input logic st, input logic ll, input logic adv, input logic swp, input string tag);
    start = st; ll_load = ll; advance = adv; buf_swap = swp;
    m_done = 0;
    if (st || ll) begin
      m_sa = cfg_src_a; m_sb = cfg_src_b; m_da = cfg_dst_a; m_db = cfg_dst_b;
      m_src = cfg_src_a; m_dst = cfg_dst_a; m_rem = cfg_count;
      m_act = (st || cfg_auto) && cfg_count != 0;
      m_sel = 0; m_pend = 0; m_dbuf = cfg_dbuf;
      m_se = cfg_src_wrap; m_sk = cfg_src_wrap_k; m_de = cfg_dst_wrap; m_dk = cfg_dst_wrap_k;
      m_step = (cfg_width == 0) ? 3'd1 : (cfg_width == 1) ? 3'd2 : 3'd4;
    end else if (m_act && adv) begin
      if (m_dbuf && (m_pend || swp)) begin
        m_sel = ~m_sel;
        m_src = m_sel ? m_sb : m_sa;
        m_dst = m_sel ? m_db : m_da;
      end else begin
        m_src = nxt(m_src, m_step, m_se, m_sk);
        m_dst = nxt(m_dst, m_step, m_de, m_dk);
      end
      m_pend = 0;
      m_rem = m_rem - 1;
      if (m_rem == 0) begin m_act = 0; m_done = 1; end
    end else if (m_act && swp && m_dbuf) begin
      m_pend = 1;
    end
    @(posedge clk); #2;
    start = 0; ll_load = 0; advance = 0; buf_swap = 0;
    chk_all(tag);
  endtask

  initial begin
    m_src = 0; m_dst = 0; m_rem = 0; m_act = 0; m_done = 0; m_sel = 0; m_pend = 0;
    m_dbuf = 0; m_se = 0; m_de = 0; m_sk = 0; m_dk = 0; m_step = 1;
    m_sa = 0; m_sb = 0; m_da = 0; m_db = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    chk_all("R1 reset");

    // R2 R3 R4 R5: sweep beat size and window exponent on both sides
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 6; k++) begin
        cfg_width = 2'(w);
        cfg_src_a = 32'hFFFF_FFF0 + 32'(k); cfg_dst_a = 32'h0001_2FF8 + 32'(3 * k);
        cfg_src_wrap = 1; cfg_src_wrap_k = 4'(k);
        cfg_dst_wrap = k[0]; cfg_dst_wrap_k = 4'(k + 1);
        cfg_dbuf = 0; cfg_count = 16'(9 + k);
        cyc(1, 0, 0, 0, "R2 start");
        for (int b = 0; b < 9 + k; b++) cyc(0, 0, 1, 0, "R3 R4 R5 step");
        cyc(0, 0, 0, 0, "R5 done clears");
        cyc(0, 0, 1, 0, "R8 idle advance");
      end
    end

    // R6: ping-pong with held and same-cycle swaps
    cfg_width = 2; cfg_src_wrap = 0; cfg_dst_wrap = 0; cfg_dbuf = 1; cfg_count = 10;
    cfg_src_a = 32'h1000_0000; cfg_src_b = 32'h2000_0000;
    cfg_dst_a = 32'h3000_0100; cfg_dst_b = 32'h4000_0200;
    cyc(1, 0, 0, 0, "R2 start pingpong");
    cyc(0, 0, 1, 0, "R6 step");
    cyc(0, 0, 0, 1, "R6 swap held");
    cyc(0, 0, 0, 0, "R6 still held");
    cyc(0, 0, 1, 0, "R6 swap at boundary");
    cyc(0, 0, 1, 0, "R6 step in alt");
    cyc(0, 0, 1, 1, "R6 swap same cycle");
    cyc(0, 0, 0, 1, "R6 swap held again");
    cyc(0, 0, 1, 1, "R6 second request merges");
    cyc(0, 0, 1, 0, "R6 step after");

    // R9: chained reload clears pending swap; auto bit governs start
    cyc(0, 0, 0, 1, "R6 pending before reload");
    cfg_src_a = 32'h0000_5000; cfg_dst_a = 32'h0000_6000; cfg_count = 4; cfg_auto = 0;
    cyc(0, 1, 0, 0, "R9 reload no auto");
    cyc(0, 0, 1, 0, "R8 advance after idle reload");
    cfg_auto = 1;
    cyc(0, 1, 0, 0, "R9 reload auto");
    cyc(0, 0, 1, 0, "R9 no stale swap");

    // R7: ping-pong off ignores swap
    cfg_dbuf = 0; cfg_count = 5;
    cyc(1, 0, 0, 0, "R2 start single buffer");
    cyc(0, 0, 0, 1, "R7 swap ignored");
    cyc(0, 0, 1, 1, "R7 swap with advance ignored");
    cyc(0, 0, 1, 0, "R7 step");

    // R10: load beats advance in the same cycle
    cfg_count = 3; cfg_src_a = 32'h0000_7000;
    cyc(1, 0, 1, 0, "R10 start with advance");
    cyc(0, 1, 1, 0, "R10 reload with advance");

    // R2: zero count stays idle
    cfg_count = 0;
    cyc(1, 0, 0, 0, "R2 zero count");
    cyc(0, 0, 1, 0, "R8 zero count advance");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule